// File: doc/BRIEF.md
# Signed-Magnitude Fraction Adder with End-Around Carry

This block adds or subtracts two 56-bit hexadecimal fractions of a floating-point add path. One operand has already been shifted right to line up with the other (the "aligned" fraction); the other is the unshifted fraction of the operand with the larger exponent (the "base" fraction). The block finds the effective operation from the two operand signs and the instruction's add/subtract sense. It then produces a result magnitude, an overflow-digit carry for additions, and the result sign.

The carry logic is a lookahead tree with three levels. Every bit pair forms a half-sum, a generate and a propagate. Four bits form a group, and two groups form a section. For a subtraction the base fraction is inverted. The carry out of the whole adder is fed back in as the low-order carry (the end-around carry). A ninth high-order bit of the top section is preset to one on subtraction. If that bit survives, no end-around carry occurred, and the complement of the sum is chosen instead of the true sum. The magnitude is therefore never negative, even though neither operand is known in advance to be the subtrahend.

The datapath is combinational. A single result register captures it when an input is presented, which gives one cycle of latency.

Top module: `fadd_eac_adder`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `res_frac`, `res_ovf` and `res_sign` are all cleared to 0.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. While `in_valid` is low the three result outputs keep their values, whatever the other inputs do.
- R3: The operation is a subtraction when `sign_alig ^ sign_base ^ op_sub` is 1. Otherwise it is an addition, with `op_sub` = 1 meaning the instruction subtracts.
- R4: On an addition, `{res_ovf, res_frac}` equals the 57-bit sum `frac_alig + frac_base`, with `res_ovf` as bit 56.
- R5: On an addition, `res_sign` equals `sign_base`.
- R6: On a subtraction, `res_frac` equals the magnitude of `frac_alig - frac_base` and `res_ovf` is 0.
- R7: On a subtraction, `res_sign` is the inverse of `sign_base` when `frac_alig > frac_base`. It is `sign_base` otherwise.
- R8: A subtraction of equal fractions gives `res_frac` = 0 with `res_sign` = `sign_base`.
- R9: Carries cross every group and section boundary. Adding all ones to 1 gives a zero fraction with `res_ovf` = 1. Subtracting a zero base from an all-ones aligned fraction gives all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present this cycle |
| op_sub | input | 1 | Instruction sense: 1 = subtract, 0 = add |
| sign_alig | input | 1 | Sign of the aligned operand |
| sign_base | input | 1 | Sign of the unshifted (larger-exponent) operand |
| frac_alig | input | 56 | Aligned (pre-shifted) fraction |
| frac_base | input | 56 | Unshifted fraction |
| out_valid | output | 1 | Result registered from the previous cycle's operands |
| res_frac | output | 56 | Result magnitude |
| res_ovf | output | 1 | Carry into the overflow digit on addition |
| res_sign | output | 1 | Result sign |

## Verification
Fixed vectors cover several cases:
- additions with and without overflow, to separate the true-sum path from the carry-out bit;
- subtractions where the aligned fraction is larger, to exercise the end-around carry with the true sum kept;
- subtractions where the base is larger, so the complemented sum must be selected;
- equal fractions, where the all-ones sum must complement to zero.

Every combination of the two signs and the instruction sense is included, so a wrong effective-operation decode shows up as a result of the wrong kind. Carry chains spanning all sections (all ones plus one) expose a broken group or section lookahead term. Random operands, with some pairs forced equal, are compared against a plain signed-magnitude model.

// File: rtl/fadd_pkg.sv
package fadd_pkg;

    localparam int unsigned FRAC_W_DEF      = 56;
    localparam int unsigned GRP_W_DEF       = 4;
    localparam int unsigned GRP_PER_SEC_DEF = 2;

    // Generate / propagate pair used at every lookahead level.
    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Combine a more significant span with the span just below it.
    function automatic gp_t gp_merge(gp_t hi, gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

    // Carry out of a span described by gp, given its carry in.
    function automatic logic gp_carry(gp_t span, logic cin);
        return span.g | (span.p & cin);
    endfunction

    // Effective subtraction from the operand signs and the instruction sense.
    function automatic logic eff_subtract(logic s_alig, logic s_base, logic sub);
        return s_alig ^ s_base ^ sub;
    endfunction

endpackage

// File: rtl/fadd_cla_group.sv
module fadd_cla_group
    import fadd_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum_true,
    output gp_t          gp
);

    logic [W-1:0] half_sum;
    gp_t  [W-1:0] bit_gp;
    logic [W-1:0] bit_cin;

    // Bit level: half-sum, generate and propagate from each bit pair.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign half_sum[i] = a[i] ^ b[i];
        assign bit_gp[i].g = a[i] & b[i];
        assign bit_gp[i].p = a[i] | b[i];
    end

    // Carry into each bit from the group carry in, via the merged span below it.
    always_comb begin
        gp_t span;
        span       = bit_gp[0];
        bit_cin[0] = cin;
        for (int i = 1; i < W; i++) begin
            bit_cin[i] = gp_carry(span, cin);
            span       = gp_merge(bit_gp[i], span);
        end
        gp = span;
    end

    assign sum_true = half_sum ^ bit_cin;

endmodule

// File: rtl/fadd_cla_section.sv
module fadd_cla_section
    import fadd_pkg::*;
#(
    parameter int unsigned GRP_W   = 4,
    parameter int unsigned N_GRP   = 2,
    localparam int unsigned SEC_W  = GRP_W * N_GRP
) (
    input  logic [SEC_W-1:0] a,
    input  logic [SEC_W-1:0] b,
    input  logic             cin,
    output logic [SEC_W-1:0] sum_true,
    output gp_t              gp
);

    gp_t  grp_gp  [N_GRP];
    logic grp_cin [N_GRP];

    for (genvar k = 0; k < N_GRP; k++) begin : g_grp
        fadd_cla_group #(.W(GRP_W)) u_grp (
            .a        (a[k*GRP_W +: GRP_W]),
            .b        (b[k*GRP_W +: GRP_W]),
            .cin      (grp_cin[k]),
            .sum_true (sum_true[k*GRP_W +: GRP_W]),
            .gp       (grp_gp[k])
        );
    end

    // Group level lookahead inside the section.
    always_comb begin
        gp_t span;
        span       = grp_gp[0];
        grp_cin[0] = cin;
        for (int k = 1; k < N_GRP; k++) begin
            grp_cin[k] = gp_carry(span, cin);
            span       = gp_merge(grp_gp[k], span);
        end
        gp = span;
    end

endmodule

// File: rtl/fadd_eac_adder.sv
module fadd_eac_adder
    import fadd_pkg::*;
#(
    parameter int unsigned FRAC_W      = FRAC_W_DEF,
    parameter int unsigned GRP_W       = GRP_W_DEF,
    parameter int unsigned GRP_PER_SEC = GRP_PER_SEC_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              op_sub,
    input  logic              sign_alig,
    input  logic              sign_base,
    input  logic [FRAC_W-1:0] frac_alig,
    input  logic [FRAC_W-1:0] frac_base,
    output logic              out_valid,
    output logic [FRAC_W-1:0] res_frac,
    output logic              res_ovf,
    output logic              res_sign
);

    localparam int unsigned SEC_W = GRP_W * GRP_PER_SEC;
    localparam int unsigned N_SEC = FRAC_W / SEC_W;

    typedef struct packed {
        logic [FRAC_W-1:0] frac;
        logic              ovf;
        logic              sign;
    } fadd_res_t;

    logic              do_sub;
    logic [FRAC_W-1:0] opnd_b;
    logic [FRAC_W-1:0] sum_true;
    gp_t               sec_gp  [N_SEC];
    logic              sec_cin [N_SEC];
    gp_t               whole_gp;
    logic              eac_cin;
    logic              top_carry;
    logic              ninth_bit;
    logic              pick_comp;
    fadd_res_t         res_d;
    fadd_res_t         res_q;

    // Effective operation (R3) and true/complement gating of the base fraction.
    assign do_sub = eff_subtract(sign_alig, sign_base, op_sub);
    assign opnd_b = do_sub ? ~frac_base : frac_base;

    for (genvar s = 0; s < N_SEC; s++) begin : g_sec
        fadd_cla_section #(.GRP_W(GRP_W), .N_GRP(GRP_PER_SEC)) u_sec (
            .a        (frac_alig[s*SEC_W +: SEC_W]),
            .b        (opnd_b[s*SEC_W +: SEC_W]),
            .cin      (sec_cin[s]),
            .sum_true (sum_true[s*SEC_W +: SEC_W]),
            .gp       (sec_gp[s])
        );
    end

    // Whole-adder generate/propagate; independent of any carry in.
    always_comb begin
        gp_t span;
        span = sec_gp[0];
        for (int s = 1; s < N_SEC; s++) begin
            span = gp_merge(sec_gp[s], span);
        end
        whole_gp = span;
    end

    // End-around carry: on subtract the top carry re-enters at the bottom.
    assign eac_cin = do_sub & whole_gp.g;

    // Section level lookahead using the end-around carry as carry in.
    always_comb begin
        gp_t span;
        span       = sec_gp[0];
        sec_cin[0] = eac_cin;
        for (int s = 1; s < N_SEC; s++) begin
            sec_cin[s] = gp_carry(span, eac_cin);
            span       = gp_merge(sec_gp[s], span);
        end
    end

    assign top_carry = gp_carry(whole_gp, eac_cin);

    // Ninth high-order bit: preset to one on subtract, then receives the top carry.
    assign ninth_bit = do_sub ^ top_carry;
    assign pick_comp = do_sub & ninth_bit;

    always_comb begin
        res_d.frac = pick_comp ? ~sum_true : sum_true;
        res_d.ovf  = ninth_bit & ~do_sub;
        res_d.sign = (do_sub & ~pick_comp) ? ~sign_base : sign_base;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_q <= res_d;
            end
        end
    end

    assign res_frac = res_q.frac;
    assign res_ovf  = res_q.ovf;
    assign res_sign = res_q.sign;

    // R2: one-cycle latency of the valid flag
    a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    // R2: result holds while no operands are presented
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |->
            ($stable(res_frac) && $stable(res_ovf) && $stable(res_sign)));

    // R4: addition gives the full 57-bit sum
    a_r4_add_sum: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(sign_alig ^ sign_base ^ op_sub)) |->
            ({res_ovf, res_frac} == ({1'b0, $past(frac_alig)} + {1'b0, $past(frac_base)})));

    // R5: addition keeps the base sign
    a_r5_add_sign: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(sign_alig ^ sign_base ^ op_sub)) |->
            (res_sign == $past(sign_base)));

    // R6: subtraction gives a magnitude and never an overflow digit
    a_r6_sub_mag: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(sign_alig ^ sign_base ^ op_sub)) |->
            (!res_ovf && (res_frac == (($past(frac_alig) > $past(frac_base)) ?
                ($past(frac_alig) - $past(frac_base)) :
                ($past(frac_base) - $past(frac_alig))))));

    // R7: subtraction sign follows the larger magnitude
    a_r7_sub_sign: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(sign_alig ^ sign_base ^ op_sub)) |->
            (res_sign == (($past(frac_alig) > $past(frac_base)) ?
                !$past(sign_base) : $past(sign_base))));

endmodule

// File: tb/fadd_eac_adder_bench.sv
`timescale 1ns/1ps
module fadd_eac_adder_bench;

    localparam int unsigned FW    = 56;
    localparam int unsigned VEC_W = 3 + 2*FW + 2 + FW;
    localparam int unsigned N_VEC = 10;
    localparam logic [FW-1:0] ONES = {FW{1'b1}};

    // Fields: sign_alig, sign_base, op_sub, frac_alig, frac_base, exp_ovf, exp_sign, exp_frac
    localparam logic [VEC_W-1:0] VEC [N_VEC] = '{
        {1'b0, 1'b0, 1'b0, 56'h1,              56'h2,              1'b0, 1'b0, 56'h3},
        {1'b0, 1'b0, 1'b0, ONES,               56'h1,              1'b1, 1'b0, 56'h0},
        {1'b0, 1'b0, 1'b1, 56'h5,              56'h3,              1'b0, 1'b1, 56'h2},
        {1'b0, 1'b0, 1'b1, 56'h3,              56'h5,              1'b0, 1'b0, 56'h2},
        {1'b0, 1'b0, 1'b1, 56'h123456789ABCDE, 56'h123456789ABCDE, 1'b0, 1'b0, 56'h0},
        {1'b1, 1'b0, 1'b0, 56'h10,             56'h80000000000000, 1'b0, 1'b0, 56'h7FFFFFFFFFFFF0},
        {1'b1, 1'b1, 1'b0, 56'h0F,             56'hF1,             1'b0, 1'b1, 56'h100},
        {1'b0, 1'b1, 1'b1, 56'h80000000000000, 56'h80000000000000, 1'b1, 1'b1, 56'h0},
        {1'b1, 1'b1, 1'b1, 56'h0,              56'h5,              1'b0, 1'b1, 56'h5},
        {1'b0, 1'b0, 1'b1, ONES,               56'h0,              1'b0, 1'b1, ONES}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic          op_sub;
    logic          sign_alig;
    logic          sign_base;
    logic [FW-1:0] frac_alig;
    logic [FW-1:0] frac_base;
    logic          out_valid;
    logic [FW-1:0] res_frac;
    logic          res_ovf;
    logic          res_sign;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    fadd_eac_adder u_fadd_eac_adder (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_sub    (op_sub),
        .sign_alig (sign_alig),
        .sign_base (sign_base),
        .frac_alig (frac_alig),
        .frac_base (frac_base),
        .out_valid (out_valid),
        .res_frac  (res_frac),
        .res_ovf   (res_ovf),
        .res_sign  (res_sign)
    );

    task automatic check(input string tag, input logic [FW+1:0] act, input logic [FW+1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Behavioural signed-magnitude model: returns {ovf, sign, frac}.
    function automatic logic [FW+1:0] model(logic sa, logic sb, logic sub,
                                            logic [FW-1:0] fa, logic [FW-1:0] fb);
        logic [FW:0] s;
        if ((sa ^ sb ^ sub) == 1'b0) begin
            s = {1'b0, fa} + {1'b0, fb};
            return {s[FW], sb, s[FW-1:0]};
        end else if (fa > fb) begin
            return {1'b0, ~sb, fa - fb};
        end else begin
            return {1'b0, sb, fb - fa};
        end
    endfunction

    task automatic apply(input logic sa, input logic sb, input logic sub,
                         input logic [FW-1:0] fa, input logic [FW-1:0] fb);
        @(negedge clk);
        sign_alig = sa; sign_base = sb; op_sub = sub;
        frac_alig = fa; frac_base = fb; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic string tag_of(logic sa, logic sb, logic sub,
                                     logic [FW-1:0] fa, logic [FW-1:0] fb);
        if ((sa ^ sb ^ sub) == 1'b0) return "R4 R5 R3";
        if (fa == fb)                return "R8 R3";
        return "R6 R7 R3";
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b1; op_sub = 1'b1; sign_alig = 1'b1; sign_base = 1'b0;
        frac_alig = ONES; frac_base = 56'h1;
        repeat (3) @(negedge clk);
        // R1: reset clears everything, even with operands presented
        check("R1 out_valid", {{(FW+1){1'b0}}, out_valid}, '0);
        check("R1 result", {res_ovf, res_sign, res_frac}, '0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R2 idle after reset", {{(FW+1){1'b0}}, out_valid}, '0);

        // Table of fixed vectors
        for (int v = 0; v < N_VEC; v++) begin
            logic          sa, sb, sub, eo, es;
            logic [FW-1:0] fa, fb, ef;
            {sa, sb, sub, fa, fb, eo, es, ef} = VEC[v];
            apply(sa, sb, sub, fa, fb);
            check("R2 valid", {{(FW+1){1'b0}}, out_valid}, {{(FW+1){1'b0}}, 1'b1});
            check(tag_of(sa, sb, sub, fa, fb), {res_ovf, res_sign, res_frac}, {eo, es, ef});
        end

        // R9: carry through every group and section
        apply(1'b0, 1'b0, 1'b0, ONES, 56'h1);
        check("R9 add ripple", {res_ovf, res_sign, res_frac}, {1'b1, 1'b0, {FW{1'b0}}});
        apply(1'b1, 1'b1, 1'b1, ONES, 56'h0);
        check("R9 sub ripple", {res_ovf, res_sign, res_frac}, {1'b0, 1'b0, ONES});

        // R2: outputs hold while in_valid is low and inputs change
        apply(1'b0, 1'b0, 1'b0, 56'h00000000000100, 56'h00000000000023);
        sign_alig = 1'b1; op_sub = 1'b1; frac_alig = ONES; frac_base = 56'h7;
        @(negedge clk);
        check("R2 hold", {res_ovf, res_sign, res_frac}, {1'b0, 1'b0, 56'h123});
        check("R2 valid low", {{(FW+1){1'b0}}, out_valid}, '0);

        // R8: equal magnitudes, both base signs
        apply(1'b1, 1'b1, 1'b1, 56'hABCDEF01234567, 56'hABCDEF01234567);
        check("R8 eq sign1", {res_ovf, res_sign, res_frac}, {1'b0, 1'b1, {FW{1'b0}}});

        // Random operands against the model, some forced equal
        for (int n = 0; n < 400; n++) begin
            logic          sa, sb, sub;
            logic [FW-1:0] fa, fb;
            sa  = 1'($urandom);
            sb  = 1'($urandom);
            sub = 1'($urandom);
            fa  = {24'($urandom), 32'($urandom)};
            fb  = {24'($urandom), 32'($urandom)};
            if (n % 16 == 3) fb = fa;
            if (n % 16 == 7) fa = fa >> (4 * ($urandom % 15));
            apply(sa, sb, sub, fa, fb);
            check(tag_of(sa, sb, sub, fa, fb), {res_ovf, res_sign, res_frac},
                  model(sa, sb, sub, fa, fb));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule